// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master that a processor drives through a small 32-bit register bus. Software queues words into a transmit FIFO, and a shift engine sends each word out on the serial clock and data-out lines. For every word sent, the engine captures one word from the data-in line into a receive FIFO. Software picks the clock polarity, the clock phase, the bit order and an internal loopback in a control register. A hold bit in the same register stops new transfers so software can fill the FIFO first. Clearing the hold bit sends the queued words back to back.

The slave-select lines are active low and come straight from a register that software writes. The block never toggles them on its own. The serial clock divider is fixed at build time by a parameter. A key word written to the reset register returns every register and both FIFOs to their reset state. The control register reads back the stored bits exactly as written, so software can use a known pattern to detect the bus byte order.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0x05 (receive empty at bit 0 and transmit empty at bit 2 set, all else clear), every slave-select line is high and the serial clock is low.
- R2: The control register keeps bits loop (bit 0), enable (1), master (2), polarity (3), phase (4), manual select (7), hold (8) and LSB-first (9), and reads them back as written. The flush bits 5 and 6 always read 0.
- R3: The transmit-full flag (status bit 3) sets when the transmit FIFO holds DEPTH words. A write to the transmit port at 0x68 while the FIFO is full is dropped.
- R4: While the hold bit is set, no serial clock edge occurs even with words queued. Clearing it sends every queued word.
- R5: With loop set, data-out is captured in place of data-in, so the receive port at 0x6C returns the words sent. With loop clear, the data-in level is captured.
- R6: The serial clock rests at the polarity bit whenever no word is shifting. With phase 0, a bit is valid on the leading clock edge. With phase 1, it is valid on the trailing edge.
- R7: With LSB-first set, bit 0 of a word goes out first. Otherwise the top bit goes out first. Both directions assemble received words in the same order.
- R8: Reading the receive port with the FIFO empty returns 0. The receive-full flag (status bit 1) sets when the FIFO holds DEPTH words.
- R9: Writing control bit 5 empties the transmit FIFO, and writing bit 6 empties the receive FIFO. Neither bit is stored.
- R10: Writing 0x0A to offset 0x40 restores the reset state of R1.
- R11: The low SS_W bits last written to offset 0x70 appear on the slave-select outputs on the next cycle.
- R12: Each word sent adds exactly one word to the receive FIFO.
- R13: A transfer starts only while both enable and master are set.

Bus reads of the status register (0x64) report mode fault at bit 4, and it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_W | Active-low slave selects |

## Verification
A register read returns its data one cycle after the strobe edge. The bench therefore asserts the strobe for one cycle and samples on the falling edge that follows. A transmit write is counted in status on the next read. A transfer begins one cycle after the write that clears the hold bit, and each word then takes 2*W*DIV+1 cycles. The bench waits a fixed margin larger than that per word before it reads the receive FIFO. A bench monitor rebuilds each word from the serial pins on the edge that the phase bit selects.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] A_SRST = 8'h40;
  localparam logic [7:0] A_CTRL = 8'h60;
  localparam logic [7:0] A_STAT = 8'h64;
  localparam logic [7:0] A_TXD  = 8'h68;
  localparam logic [7:0] A_RXD  = 8'h6C;
  localparam logic [7:0] A_SSEL = 8'h70;
  localparam int C_LOOP = 0, C_EN = 1, C_MST = 2, C_CPOL = 3, C_CPHA = 4;
  localparam int C_TXCLR = 5, C_RXCLR = 6, C_MANSS = 7, C_HOLD = 8, C_LSB = 9;
  localparam logic [9:0]  CTRL_KEEP = 10'h39F;
  localparam logic [31:0] SRST_KEY  = 32'h0000_000A;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= din;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W = 8,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] word,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb,
  input  logic         loop,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         sclk,
  output logic         mosi
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int EW = $clog2(2*W) + 1;
  localparam int LAST = 2*W - 1;

  logic [CW-1:0] cnt;
  logic [EW-1:0] ecnt;
  logic          ph;
  logic [W-1:0]  tx_sh, rx_sh;
  logic          tick, smp, cur, rxbit;

  assign tick  = busy && (cnt == CW'(DIV-1));
  assign smp   = (~ecnt[0]) ^ cpha;
  assign cur   = lsb ? tx_sh[0] : tx_sh[W-1];
  assign rxbit = loop ? mosi : miso;
  assign sclk  = cpol ^ ph;
  assign rx_word = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; ecnt <= '0; ph <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; mosi <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1; cnt <= '0; ecnt <= '0; ph <= 1'b0;
        if (cpha) tx_sh <= word;
        else begin
          mosi  <= lsb ? word[0] : word[W-1];
          tx_sh <= lsb ? (word >> 1) : (word << 1);
        end
      end else if (busy) begin
        if (tick) begin
          cnt  <= '0;
          ph   <= ~ph;
          ecnt <= ecnt + 1'b1;
          if (smp) rx_sh <= lsb ? {rxbit, rx_sh[W-1:1]} : {rx_sh[W-2:0], rxbit};
          else begin
            mosi  <= cur;
            tx_sh <= lsb ? (tx_sh >> 1) : (tx_sh << 1);
          end
          if (ecnt == EW'(LAST)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int W = 8,
  parameter int DEPTH = 16,
  parameter int DIV = 2,
  parameter int SS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [SS_W-1:0] ss_n
);
  localparam int CW = $clog2(DEPTH+1);

  logic [9:0]   ctrl_q;
  logic         srst_q, lrst;
  logic         tx_push, tx_full, tx_empty, tx_flush;
  logic         rx_pop, rx_full, rx_empty, rx_flush;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [W-1:0] tx_dout, rx_dout, rx_word;
  logic         start, busy, done;
  logic         wr_ctrl;

  assign lrst     = rst || srst_q;
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign tx_flush = wr_ctrl && bus_wdata[C_TXCLR];
  assign rx_flush = wr_ctrl && bus_wdata[C_RXCLR];
  assign tx_push  = bus_wr && (bus_addr == A_TXD);
  assign rx_pop   = bus_rd && (bus_addr == A_RXD);
  assign start    = ctrl_q[C_EN] && ctrl_q[C_MST] && !ctrl_q[C_HOLD] && !tx_empty && !busy;

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(lrst), .flush(tx_flush), .push(tx_push), .pop(start),
    .din(bus_wdata[W-1:0]), .dout(tx_dout), .full(tx_full), .empty(tx_empty), .cnt(tx_cnt));

  spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(lrst), .flush(rx_flush), .push(done), .pop(rx_pop),
    .din(rx_word), .dout(rx_dout), .full(rx_full), .empty(rx_empty), .cnt(rx_cnt));

  spim_shift #(.W(W), .DIV(DIV)) u_sh (
    .clk(clk), .rst(lrst), .start(start), .word(tx_dout),
    .cpol(ctrl_q[C_CPOL]), .cpha(ctrl_q[C_CPHA]), .lsb(ctrl_q[C_LSB]), .loop(ctrl_q[C_LOOP]),
    .miso(miso), .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk), .mosi(mosi));

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= bus_wr && (bus_addr == A_SRST) && (bus_wdata == SRST_KEY);
  end

  always_ff @(posedge clk) begin
    if (lrst) begin
      ctrl_q <= '0;
      ss_n   <= '1;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[9:0] & CTRL_KEEP;
      if (bus_addr == A_SSEL) ss_n   <= bus_wdata[SS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (lrst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= {22'd0, ctrl_q};
        A_STAT:  bus_rdata <= {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
        A_RXD:   bus_rdata <= rx_empty ? 32'd0 : 32'(rx_dout);
        A_SSEL:  bus_rdata <= 32'(ss_n);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int DEPTH = 16,
  parameter int SS_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       srst_q,
  input logic                       busy,
  input logic                       sclk,
  input logic [9:0]                 ctrl_q,
  input logic                       tx_full,
  input logic                       tx_push,
  input logic                       start,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic                       done,
  input logic                       rx_full,
  input logic                       rx_pop,
  input logic                       rx_flush,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
  input logic                       bus_wr,
  input logic [7:0]                 bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [SS_W-1:0]            ss_n
);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (rst || srst_q)
    !busy |-> (sclk == ctrl_q[3]));
  // R4
  hold_start_chk: assert property (@(posedge clk) disable iff (rst || srst_q)
    (ctrl_q[8] && !busy) |=> !busy);
  // R13
  enable_start_chk: assert property (@(posedge clk) disable iff (rst || srst_q)
    (!ctrl_q[1] && !busy) |=> !busy);
  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (rst || srst_q)
    (tx_full && tx_push && !start && !(bus_wr && bus_addr == 8'h60)) |=> (tx_cnt == $past(tx_cnt)));
  // R12
  rx_push_chk: assert property (@(posedge clk) disable iff (rst || srst_q)
    (done && !rx_full && !rx_pop && !rx_flush) |=> (rx_cnt == $past(rx_cnt) + 1'b1));
  // R11
  ss_write_chk: assert property (@(posedge clk) disable iff (rst || srst_q)
    (bus_wr && bus_addr == 8'h70) |=> (ss_n == $past(bus_wdata[SS_W-1:0])));
endmodule

bind spim_ctrl spim_chk #(.DEPTH(DEPTH), .SS_W(SS_W)) u_chk (
  .clk(clk), .rst(rst), .srst_q(srst_q), .busy(busy), .sclk(sclk), .ctrl_q(ctrl_q),
  .tx_full(tx_full), .tx_push(tx_push), .start(start), .tx_cnt(tx_cnt),
  .done(done), .rx_full(rx_full), .rx_pop(rx_pop), .rx_flush(rx_flush), .rx_cnt(rx_cnt),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ss_n(ss_n));

// File: tb/spim_ctrl_test.sv
module spim_ctrl_test;
  localparam int W = 8, DEPTH = 16, DIV = 2, SS_W = 32;
  localparam int WT = 2*W*DIV + 8;
  localparam logic [31:0] EN = 32'h2, MST = 32'h4, LOOP = 32'h1, HOLD = 32'h100;

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0, miso = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi;
  logic [SS_W-1:0] ss_n;

  spim_ctrl #(.W(W), .DEPTH(DEPTH), .DIV(DIV), .SS_W(SS_W)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n));

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  logic cpol_b = 0, cpha_b = 0, sprev = 0;
  logic [W-1:0] mon_sh = 0;
  logic [W-1:0] mon_w [64];
  int mon_bits = 0, mon_n = 0, edge_cnt = 0;

  always @(negedge clk) begin
    if (sclk !== sprev) begin
      edge_cnt = edge_cnt + 1;
      if (((sprev == cpol_b) ^ cpha_b) == 1'b1) begin
        mon_sh = {mon_sh[W-2:0], mosi};
        mon_bits = mon_bits + 1;
        if (mon_bits == W) begin
          if (mon_n < 64) mon_w[mon_n] = mon_sh;
          mon_n = mon_n + 1;
          mon_bits = 0;
        end
      end
    end
    sprev = sclk;
  end

  function automatic logic [W-1:0] rev(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic mon_clr();
    @(negedge clk); mon_n = 0; mon_bits = 0; edge_cnt = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [W-1:0] tw [DEPTH+1];
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(8'h60, d); chk("R1 ctrl", d, 0);
    rd(8'h64, d); chk("R1 status", d, 32'h5);
    chk("R1 ss_n", 32'(ss_n), 32'hFFFF_FFFF);
    chk("R1 sclk", 32'(sclk), 0);
    // R2 readback
    wr(8'h60, 32'h1); rd(8'h60, d); chk("R2 loop readback", d, 32'h1);
    wr(8'h60, 32'h3FF); rd(8'h60, d); chk("R2 all bits", d, 32'h39F);
    wr(8'h60, 32'h0);
    // R11 slave select
    wr(8'h70, 32'hFFFF_FFFE); chk("R11 ss0", 32'(ss_n), 32'hFFFF_FFFE);
    wr(8'h70, 32'h7FFF_FFFF); chk("R11 ss31", 32'(ss_n), 32'h7FFF_FFFF);
    // R5 R6 R7 R12 across modes
    for (int m = 0; m < 8; m++) begin
      logic lsbm;
      cpol_b = m[0]; cpha_b = m[1]; lsbm = m[2];
      wr(8'h60, EN | MST | LOOP | HOLD | (32'(m[0]) << 3) | (32'(m[1]) << 4) | (32'(lsbm) << 9));
      repeat (3) @(negedge clk);
      sprev = sclk;
      chk("R6 idle level", 32'(sclk), 32'(cpol_b));
      mon_clr();
      for (int i = 0; i < 3; i++) begin
        tw[i] = W'($urandom);
        wr(8'h68, 32'(tw[i]));
      end
      wr(8'h60, EN | MST | LOOP | (32'(m[0]) << 3) | (32'(m[1]) << 4) | (32'(lsbm) << 9));
      repeat (3*WT + 10) @(negedge clk);
      chk("R12 words on wire", mon_n, 3);
      chk("R6 rest after burst", 32'(sclk), 32'(cpol_b));
      for (int i = 0; i < 3; i++) begin
        chk(lsbm ? "R7 lsb-first wire order" : "R6 wire bits", 32'(mon_w[i]), 32'(lsbm ? rev(tw[i]) : tw[i]));
        rd(8'h6C, d); chk("R5 loop data", d, 32'(tw[i]));
      end
      rd(8'h64, d); chk("R12 rx drained", d & 32'h1, 32'h1);
    end
    cpol_b = 0; cpha_b = 0;
    // R4 hold
    wr(8'h60, EN | MST | LOOP | HOLD);
    repeat (3) @(negedge clk);
    sprev = sclk; mon_clr();
    wr(8'h68, 32'h3C); wr(8'h68, 32'hC3);
    repeat (100) @(negedge clk);
    chk("R4 no edges while held", edge_cnt, 0);
    rd(8'h64, d); chk("R4 rx empty while held", d & 32'h1, 32'h1);
    wr(8'h60, EN | MST | LOOP);
    repeat (2*WT + 10) @(negedge clk);
    chk("R4 both sent", mon_n, 2);
    rd(8'h6C, d); chk("R4 first", d, 32'h3C);
    rd(8'h6C, d); chk("R4 second", d, 32'hC3);
    // R13 enable required
    wr(8'h60, MST | LOOP);
    mon_clr();
    wr(8'h68, 32'h11);
    repeat (60) @(negedge clk);
    chk("R13 no shift without enable", edge_cnt, 0);
    wr(8'h60, EN | MST | LOOP);
    repeat (WT + 10) @(negedge clk);
    rd(8'h6C, d); chk("R13 sent after enable", d, 32'h11);
    // R5 external data in
    wr(8'h60, EN | MST);
    miso = 1; wr(8'h68, 32'h5A); repeat (WT + 10) @(negedge clk);
    rd(8'h6C, d); chk("R5 miso ones", d, 32'hFF);
    miso = 0; wr(8'h68, 32'hA5); repeat (WT + 10) @(negedge clk);
    rd(8'h6C, d); chk("R5 miso zeros", d, 32'h00);
    // R3 R8 depth and full flags
    wr(8'h60, EN | MST | LOOP | HOLD);
    for (int i = 0; i <= DEPTH; i++) begin
      tw[i] = W'(i*13 + 7);
      wr(8'h68, 32'(tw[i]));
      if (i == DEPTH - 2) begin rd(8'h64, d); chk("R3 not full early", d & 32'h8, 0); end
      if (i == DEPTH - 1) begin rd(8'h64, d); chk("R3 full at depth", d & 32'h8, 32'h8); end
    end
    wr(8'h60, EN | MST | LOOP);
    repeat (DEPTH*WT + 20) @(negedge clk);
    rd(8'h64, d); chk("R8 rx full flag", d & 32'h2, 32'h2);
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h6C, d); chk("R3 queued word", d, 32'(tw[i]));
    end
    rd(8'h6C, d); chk("R3 extra dropped / R8 empty read", d, 0);
    // R9 flushes
    wr(8'h60, EN | MST | LOOP | HOLD);
    wr(8'h68, 32'h1); wr(8'h68, 32'h2);
    wr(8'h60, EN | MST | LOOP | HOLD | 32'h20);
    rd(8'h64, d); chk("R9 tx flushed", d & 32'h4, 32'h4);
    rd(8'h60, d); chk("R9 flush bit not kept", d, EN | MST | LOOP | HOLD);
    wr(8'h60, EN | MST | LOOP);
    wr(8'h68, 32'h77); wr(8'h68, 32'h78);
    repeat (2*WT + 10) @(negedge clk);
    wr(8'h60, EN | MST | LOOP | 32'h40);
    rd(8'h64, d); chk("R9 rx flushed", d & 32'h1, 32'h1);
    // R10 soft reset
    wr(8'h60, EN | MST | LOOP | HOLD | 32'h8);
    wr(8'h70, 32'h0);
    wr(8'h68, 32'h99);
    wr(8'h40, 32'h0A);
    @(negedge clk);
    rd(8'h60, d); chk("R10 ctrl", d, 0);
    rd(8'h64, d); chk("R10 status", d, 32'h5);
    chk("R10 ss_n", 32'(ss_n), 32'hFFFF_FFFF);
    chk("R10 sclk", 32'(sclk), 0);
    summary();
  end
endmodule